// File: doc/BRIEF.md
# Calendar Counter with Masked Alarm

This block keeps wall-clock time and date in one 32-bit word: second, minute, hour, day of month, month and a 6-bit year offset. The offset counts from a base year that is a leap year, so every offset divisible by four has a 29-day February. The count advances once for each rising edge of a one-per-second tick, and only while the block is enabled. Software loads the whole word in one write and reads it back at any time.

A comparator matches the running count against a 32-bit alarm word. A select code chooses how many fields, counting up from seconds, take part in the match. A match sets a sticky alarm flag on the following tick. When clear-on-match is chosen, that same tick also returns the count to its base value and sets the sticky overflow flag. The overflow flag is also set when the count passes the last second of year offset 63. Hours run either 0..23 or as a 12-hour value with a PM bit. The 12/24 selection can only be changed while counting is stopped.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the count is 0x00420000 (00:00:00, day 1, month 1, year 0), both flags are 0 and 24-hour mode is selected (h12_o = 0).
- R2: The count advances by exactly one second per rising edge of tick_i while en_i is 1. A tick held high for several cycles advances it once, and ticks while en_i is 0 leave it unchanged.
- R3: Bit layout: sc[5:0], mn[11:6], hr[16:12], day[21:17], mon[25:22], yr[31:26]. Seconds carry into minutes at 59 and minutes into hours at 59. In 24-hour mode 23:59:59 becomes 00:00:00 of the next day.
- R4: Day of month runs from 1 up to the month length, then rolls to 1 of the next month. Months 4, 6, 9 and 11 have 30 days, and month 2 has 29 days when yr[1:0] = 0 and 28 otherwise. The other months have 31 days, and month 12 rolls to month 1 of the next year.
- R5: One second after 23:59:59 on day 31, month 12, year 63 the count wraps to the base value and the overflow flag is set.
- R6: In 12-hour mode hr[3:0] holds 12,1..11 and hr[4] = 1 means PM. 11:59:59 becomes 12:00:00 with hr[4] toggled, 12:59:59 becomes 1:00:00 with hr[4] kept, and the day advances only at 11:59:59 PM. The base value's hour there is 12 AM (0x0C).
- R7: A write of the 12/24 mode bit (h12_wr_i, h12_i = 1 for 12-hour) takes effect only while en_i is 0.
- R8: On a counting tick where the count matches the alarm word under the select code, the alarm flag is set, i.e. one tick after the count reached the alarm value.
- R9: Select code s = 1..6 compares the lowest s fields (1 = seconds, 2 = + minutes, 3 = + hours, 4 = + day, 5 = + month, 6 = all). Fields above them are ignored, and codes 0 and 7 never match.
- R10: With match_clr_i = 1, a matching tick loads the base value instead of incrementing and sets the alarm and overflow flags together.
- R11: Flags are sticky. Writing 1 to flag_clr_i[0] clears overflow and writing 1 to flag_clr_i[1] clears alarm.
- R12: A write to the count (time_we_i) loads all fields on the next edge and takes priority over a simultaneous tick. That tick neither increments the count nor sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counting enable |
| tick_i | input | 1 | One-per-second count tick (rising edge counts) |
| h12_wr_i | input | 1 | Write strobe for the hour-mode bit |
| h12_i | input | 1 | Hour mode to write: 1 = 12-hour, 0 = 24-hour |
| time_we_i | input | 1 | Write strobe for the time/date word |
| time_wdata_i | input | 32 | Time/date word to load |
| alarm_i | input | 32 | Alarm time/date word |
| mask_sel_i | input | 3 | Alarm field select code |
| match_clr_i | input | 1 | Clear the count on alarm match |
| flag_clr_i | input | 2 | Write-1-to-clear: bit 0 overflow, bit 1 alarm |
| time_o | output | 32 | Current time/date word |
| h12_o | output | 1 | Current hour mode |
| ovf_o | output | 1 | Sticky overflow flag |
| alarm_o | output | 1 | Sticky alarm flag |

## Verification
The counter is driven from words placed one second before each carry boundary. These cover a plain minute carry, a 30-day month end, February in a non-leap and a leap offset, a 31-day January, a December year change and the final wrap at offset 63, so each month-length and carry path is exercised on its own. In 12-hour mode the 11 AM, 12 PM and 11 PM boundaries separate the PM toggle from the 12-to-1 step and from the day carry. Alarm tests use equal words under codes 0 and 7, words that differ only in an unselected field, and a word that differs in a selected minute field. These show whether the select code, not plain equality, decides the match, and the clear-on-match case confirms both flags rise on the same tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int TIME_W     = 32;
  localparam int NUM_FIELDS = 6;
  localparam int YR_TOP     = 63;

  typedef struct packed {
    logic [5:0] yr;
    logic [3:0] mon;
    logic [4:0] day;
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } rtc_time_t;

  function automatic int fld_lsb(input int idx);
    case (idx)
      0: return 0;
      1: return 6;
      2: return 12;
      3: return 17;
      4: return 22;
      5: return 26;
      default: return TIME_W;
    endcase
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [5:0] yr);
    case (mon)
      4'd2: return (yr[1:0] == 2'd0) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default: return 5'd31;
    endcase
  endfunction

  function automatic rtc_time_t base_time(input logic h12);
    rtc_time_t t;
    t     = '0;
    t.day = 5'd1;
    t.mon = 4'd1;
    t.hr  = h12 ? 5'd12 : 5'd0;
    return t;
  endfunction
endpackage

// File: rtl/rtc_time_inc.sv
module rtc_time_inc
  import rtc_pkg::*;
(
  input  rtc_time_t cur_i,
  input  logic      h12_i,
  output rtc_time_t nxt_o,
  output logic      wrap_o
);
  logic sc_c, mn_c, hr_top, day_c, mon_c, yr_c;
  logic [3:0] hr_lo;

  assign hr_lo  = cur_i.hr[3:0];
  assign sc_c   = (cur_i.sc == 6'd59);
  assign mn_c   = sc_c && (cur_i.mn == 6'd59);
  assign hr_top = h12_i ? (cur_i.hr == 5'h1B) : (cur_i.hr == 5'd23);
  assign day_c  = mn_c && hr_top;
  assign mon_c  = day_c && (cur_i.day == month_len(cur_i.mon, cur_i.yr));
  assign yr_c   = mon_c && (cur_i.mon == 4'd12);
  assign wrap_o = yr_c && (cur_i.yr == 6'(YR_TOP));

  always_comb begin
    nxt_o    = cur_i;
    nxt_o.sc = sc_c ? 6'd0 : cur_i.sc + 6'd1;
    if (sc_c) nxt_o.mn = mn_c ? 6'd0 : cur_i.mn + 6'd1;
    if (mn_c) begin
      if (!h12_i)             nxt_o.hr = hr_top ? 5'd0 : cur_i.hr + 5'd1;
      else if (hr_lo == 4'd11) nxt_o.hr = {~cur_i.hr[4], 4'd12};
      else if (hr_lo == 4'd12) nxt_o.hr = {cur_i.hr[4], 4'd1};
      else                     nxt_o.hr = {cur_i.hr[4], hr_lo + 4'd1};
    end
    if (day_c) nxt_o.day = mon_c ? 5'd1 : cur_i.day + 5'd1;
    if (mon_c) nxt_o.mon = yr_c ? 4'd1 : cur_i.mon + 4'd1;
    if (yr_c)  nxt_o.yr  = cur_i.yr + 6'd1;
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic [TIME_W-1:0] cur_i,
  input  logic [TIME_W-1:0] alarm_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              match_o
);
  logic [NUM_FIELDS-1:0] eq, need;
  logic sel_ok;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam int LO = fld_lsb(g);
    localparam int HI = fld_lsb(g + 1) - 1;
    assign eq[g]   = (cur_i[HI:LO] == alarm_i[HI:LO]);
    assign need[g] = (int'(sel_i) > g);
  end

  assign sel_ok  = (sel_i != '0) && (int'(sel_i) <= NUM_FIELDS);
  assign match_o = sel_ok && (&(eq | ~need));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              h12_wr_i,
  input  logic              h12_i,
  input  logic              time_we_i,
  input  logic [TIME_W-1:0] time_wdata_i,
  input  logic [TIME_W-1:0] alarm_i,
  input  logic [SEL_W-1:0]  mask_sel_i,
  input  logic              match_clr_i,
  input  logic [1:0]        flag_clr_i,
  output logic [TIME_W-1:0] time_o,
  output logic              h12_o,
  output logic              ovf_o,
  output logic              alarm_o
);
  rtc_time_t cnt_q, cnt_nxt;
  logic tick_q, adv, wrap, match, ovf_set, alm_set;
  logic h12_q, ovf_q, alm_q;

  rtc_time_inc u_inc (
    .cur_i  (cnt_q),
    .h12_i  (h12_q),
    .nxt_o  (cnt_nxt),
    .wrap_o (wrap)
  );

  rtc_alarm_cmp #(.SEL_W(SEL_W)) u_cmp (
    .cur_i   (cnt_q),
    .alarm_i (alarm_i),
    .sel_i   (mask_sel_i),
    .match_o (match)
  );

  // write wins over tick: no advance, no flag
  assign adv     = en_i && tick_i && !tick_q && !time_we_i;
  assign alm_set = adv && match;
  assign ovf_set = adv && (wrap || (match && match_clr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      h12_q  <= 1'b0;
      cnt_q  <= base_time(1'b0);
      ovf_q  <= 1'b0;
      alm_q  <= 1'b0;
    end else begin
      tick_q <= tick_i;
      if (h12_wr_i && !en_i) h12_q <= h12_i;
      if (time_we_i)  cnt_q <= rtc_time_t'(time_wdata_i);
      else if (adv)   cnt_q <= (match && match_clr_i) ? base_time(h12_q) : cnt_nxt;
      ovf_q <= (ovf_q & ~flag_clr_i[0]) | ovf_set;
      alm_q <= (alm_q & ~flag_clr_i[1]) | alm_set;
    end
  end

  assign time_o  = cnt_q;
  assign h12_o   = h12_q;
  assign ovf_o   = ovf_q;
  assign alarm_o = alm_q;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              time_we_i,
  input logic [TIME_W-1:0] time_wdata_i,
  input logic [SEL_W-1:0]  mask_sel_i,
  input logic [1:0]        flag_clr_i,
  input logic [TIME_W-1:0] time_o,
  input logic              h12_o,
  input logic              ovf_o,
  input logic              alarm_o
);
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !time_we_i) |=> $stable(time_o));

  p_load_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_we_i |=> (time_o == $past(time_wdata_i)));

  p_mode_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> $stable(h12_o));

  p_ovf_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !flag_clr_i[0]) |=> ovf_o);

  p_alm_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && !flag_clr_i[1]) |=> alarm_o);

  p_ovf_base_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> (time_o == {6'd0, 4'd1, 5'd1, (h12_o ? 5'd12 : 5'd0), 12'd0}));

  p_sel_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> ($past(mask_sel_i) != '0 && int'($past(mask_sel_i)) <= NUM_FIELDS));
endmodule

bind rtc_calendar rtc_calendar_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .time_we_i    (time_we_i),
  .time_wdata_i (time_wdata_i),
  .mask_sel_i   (mask_sel_i),
  .flag_clr_i   (flag_clr_i),
  .time_o       (time_o),
  .h12_o        (h12_o),
  .ovf_o        (ovf_o),
  .alarm_o      (alarm_o)
);

// File: tb/sim_rtc_calendar.sv
`timescale 1ns/1ps
module sim_rtc_calendar;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic en_i = 0, tick_i = 0, h12_wr_i = 0, h12_i = 0, time_we_i = 0, match_clr_i = 0;
  logic [31:0] time_wdata_i = '0, alarm_i = '0;
  logic [2:0]  mask_sel_i = '0;
  logic [1:0]  flag_clr_i = '0;
  logic [31:0] time_o;
  logic h12_o, ovf_o, alarm_o;

  always #10 clk_i = ~clk_i;

  rtc_calendar u0 (.*);

  typedef struct {
    string       req;
    logic [31:0] t;
    logic        h, o, a;
  } item_t;
  item_t q[$];

  int checks = 0, errors = 0;
  logic done = 0;
  logic [31:0] exp_t = 32'h0042_0000;
  logic exp_h = 0, exp_o = 0, exp_a = 0;

  function automatic logic [31:0] pk(int y, int m, int d, int h, int mi, int s);
    return {6'(y), 4'(m), 5'(d), 5'(h), 6'(mi), 6'(s)};
  endfunction

  task automatic put(string req);
    item_t it;
    it.req = req; it.t = exp_t; it.h = exp_h; it.o = exp_o; it.a = exp_a;
    q.push_back(it);
  endtask

  task automatic wr(logic [31:0] v);
    @(negedge clk_i); time_we_i = 1; time_wdata_i = v;
    @(negedge clk_i); time_we_i = 0;
    exp_t = v;
  endtask

  task automatic tk();
    @(negedge clk_i); tick_i = 1;
    @(negedge clk_i); tick_i = 0;
  endtask

  task automatic set_mode(logic m);
    @(negedge clk_i); h12_wr_i = 1; h12_i = m;
    @(negedge clk_i); h12_wr_i = 0;
  endtask

  task automatic clr_flags(logic [1:0] f);
    @(negedge clk_i); flag_clr_i = f;
    @(negedge clk_i); flag_clr_i = 0;
  endtask

  // monitor
  initial forever begin
    item_t it;
    wait (q.size() > 0);
    #1;
    it = q.pop_front();
    checks++;
    if (time_o !== it.t || h12_o !== it.h || ovf_o !== it.o || alarm_o !== it.a) begin
      errors++;
      $display("FAIL %s: time=%h h12=%b ovf=%b alm=%b expected time=%h h12=%b ovf=%b alm=%b",
               it.req, time_o, h12_o, ovf_o, alarm_o, it.t, it.h, it.o, it.a);
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    put("R1 reset");

    wr(pk(5, 3, 10, 8, 15, 30)); put("R12 load");
    tk(); put("R2 disabled tick");
    en_i = 1;
    @(negedge clk_i); tick_i = 1;
    repeat (3) @(negedge clk_i);
    tick_i = 0;
    @(negedge clk_i);
    exp_t = pk(5, 3, 10, 8, 15, 31); put("R2 held tick once");

    wr(pk(1, 6, 14, 13, 59, 59)); tk(); exp_t = pk(1, 6, 14, 14, 0, 0); put("R3 hour carry");
    wr(pk(1, 4, 30, 23, 59, 59)); tk(); exp_t = pk(1, 5, 1, 0, 0, 0); put("R3 R4 30-day end");
    wr(pk(2, 2, 28, 23, 59, 59)); tk(); exp_t = pk(2, 3, 1, 0, 0, 0); put("R4 feb non-leap");
    wr(pk(4, 2, 28, 23, 59, 59)); tk(); exp_t = pk(4, 2, 29, 0, 0, 0); put("R4 feb leap 28");
    wr(pk(4, 2, 29, 23, 59, 59)); tk(); exp_t = pk(4, 3, 1, 0, 0, 0); put("R4 feb leap 29");
    wr(pk(7, 1, 31, 23, 59, 59)); tk(); exp_t = pk(7, 2, 1, 0, 0, 0); put("R4 31-day end");
    wr(pk(7, 12, 31, 23, 59, 59)); tk(); exp_t = pk(8, 1, 1, 0, 0, 0); put("R4 year change");

    wr(pk(63, 12, 31, 23, 59, 59)); tk();
    exp_t = 32'h0042_0000; exp_o = 1; put("R5 wrap");
    clr_flags(2'b01); exp_o = 0; put("R11 ovf clear");

    @(negedge clk_i); time_we_i = 1; time_wdata_i = pk(9, 9, 9, 9, 9, 9); tick_i = 1;
    @(negedge clk_i); time_we_i = 0; tick_i = 0;
    exp_t = pk(9, 9, 9, 9, 9, 9); put("R12 write beats tick");

    set_mode(1); put("R7 mode write ignored when enabled");
    en_i = 0; set_mode(1); exp_h = 1; put("R7 mode write when disabled");
    en_i = 1;

    wr(pk(0, 1, 1, 11, 59, 59)); tk(); exp_t = pk(0, 1, 1, 28, 0, 0); put("R6 11am to 12pm");
    wr(pk(0, 1, 1, 28, 59, 59)); tk(); exp_t = pk(0, 1, 1, 17, 0, 0); put("R6 12pm to 1pm");
    wr(pk(0, 1, 5, 27, 59, 59)); tk(); exp_t = pk(0, 1, 6, 12, 0, 0); put("R6 11pm day carry");
    en_i = 0; set_mode(0); exp_h = 0; en_i = 1;

    mask_sel_i = 1; alarm_i = pk(9, 9, 9, 9, 9, 10);
    wr(pk(0, 1, 1, 0, 0, 9)); tk(); exp_t = pk(0, 1, 1, 0, 0, 10); put("R8 no flag on reaching match");
    tk(); exp_t = pk(0, 1, 1, 0, 0, 11); exp_a = 1; put("R8 flag one tick later");
    clr_flags(2'b10); exp_a = 0; put("R11 alarm clear");

    mask_sel_i = 0; alarm_i = pk(0, 1, 1, 0, 0, 11);
    tk(); exp_t = pk(0, 1, 1, 0, 0, 12); put("R9 code 0 never matches");
    mask_sel_i = 7; alarm_i = pk(0, 1, 1, 0, 0, 12);
    tk(); exp_t = pk(0, 1, 1, 0, 0, 13); put("R9 code 7 never matches");
    mask_sel_i = 2; alarm_i = pk(0, 1, 1, 0, 5, 13);
    tk(); exp_t = pk(0, 1, 1, 0, 0, 14); put("R9 selected minute differs");
    mask_sel_i = 6; alarm_i = pk(0, 1, 1, 0, 0, 14);
    tk(); exp_t = pk(0, 1, 1, 0, 0, 15); exp_a = 1; put("R8 full match");
    clr_flags(2'b10); exp_a = 0;
    mask_sel_i = 3; alarm_i = pk(9, 9, 9, 0, 0, 15);
    tk(); exp_t = pk(0, 1, 1, 0, 0, 16); exp_a = 1; put("R9 upper fields ignored");
    clr_flags(2'b10); exp_a = 0;

    mask_sel_i = 1; alarm_i = pk(0, 1, 1, 0, 0, 20); match_clr_i = 1;
    wr(pk(3, 5, 7, 6, 30, 20)); tk();
    exp_t = 32'h0042_0000; exp_o = 1; exp_a = 1; put("R10 clear on match");
    tk(); exp_t = pk(0, 1, 1, 0, 0, 1); put("R10 counts on after clear");

    repeat (3) @(negedge clk_i);
    wait (q.size() == 0);
    #2;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule